// File: doc/BRIEF.md
# Error-Correcting Time-Update Receiver with 12-Hour Clock

The block accepts a 15-bit time-update word from a radio receiver, presented in parallel with a one-cycle valid strobe. The word carries eleven payload bits and four check bits of a single-error-correcting linear code. The block computes a four-bit syndrome, maps any nonzero syndrome to the one word position it names, and flips that bit. It then unpacks the corrected payload into an hour, a minute and an afternoon flag.

A payload that holds a legal time overwrites a free-running 12-hour clock. The clock otherwise advances on a one-second tick input. Two one-cycle status pulses report a corrected bit and a rejected payload. Serial framing, the radio and display driving sit outside the block.

Top module: `clkupd_top`

## Requirements
- R1: The word layout is payload in bits 14..4 and check bits in 3..0. Each position has a 4-bit parity column. Check bit k (k=0..3) has the column with only bit k set. Payload positions 14 down to 4 take, in order, the weight-2 vectors 3, 5, 6, 9, 10, 12, then the weight-3 vectors 7, 11, 13, 14, then 15. The syndrome is the XOR of the columns of all set bits.
- R2: A word with a zero syndrome is used unchanged, and the error pulse stays low.
- R3: A nonzero syndrome flips the single position whose column equals it. `err_fixed_o` is high for exactly the cycle after the strobe.
- R4: Hour is in corrected bits 14..11, minute in bits 10..5, and the afternoon flag (1 = PM) in bit 4. A legal strobed word shows on the outputs in the cycle after the strobe.
- R5: A corrected hour outside 1..12, or a minute above 59, raises `bad_time_o` for the cycle after the strobe and leaves the time unchanged.
- R6: A legal update clears the seconds count. The minute then advances after exactly TICKS_PER_MIN further ticks, and the time holds while neither strobe nor tick is present.
- R7: Each TICKS_PER_MIN-th tick advances the minute. Minute 59 wraps to 0 and advances the hour, and hour 12 wraps to 1.
- R8: The afternoon flag toggles when the hour steps from 11 to 12.
- R9: After reset the time reads 12:00 AM and both pulses are low.
- R10: When a legal update and a tick arrive in the same cycle, the update wins and the tick is lost.
- R11: Two flipped bits are not detected as such. The block applies its single-bit correction, which can yield a wrong time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Strobe for `cw_word` |
| cw_word | input | 15 | Received codeword |
| sec_tick | input | 1 | One-second tick |
| hour_o | output | 4 | Current hour, 1..12 |
| minute_o | output | 6 | Current minute, 0..59 |
| pm_o | output | 1 | Afternoon flag |
| err_fixed_o | output | 1 | Pulse: a bit was corrected |
| bad_time_o | output | 1 | Pulse: payload rejected |

## Verification
The bench builds the block with TICKS_PER_MIN set to 4, so that minute, hour and afternoon rollovers come within a few dozen ticks. This makes it possible to walk through 11:59 to 12:00 in both halves of the day, and 12:59 to 1:00. With this setting the bench also checks that the seconds count restarts after an update mid-minute. Every one of the fifteen single-bit flips, and a set of double flips, is applied over several payloads, including hours of 0 and 13 and a minute of 60.

// File: rtl/clkupd_pkg.sv
package clkupd_pkg;
  localparam int WORD_W = 15;
  localparam int CHK_W  = 4;
  localparam int DATA_W = WORD_W - CHK_W;
  localparam int HOUR_W = 4;
  localparam int MIN_W  = 6;

  // Parity column of one word position. Check positions are unit
  // vectors; payload positions, from the top bit down, walk through
  // all vectors of weight 2, then 3, then 4, each group ascending.
  function automatic logic [CHK_W-1:0] hcol(input int bitpos);
    logic [CHK_W-1:0] r;
    int idx;
    int target;
    r = '0;
    if (bitpos < CHK_W) begin
      r[bitpos] = 1'b1;
    end else begin
      target = WORD_W - 1 - bitpos;
      idx = 0;
      for (int w = 2; w <= CHK_W; w++) begin
        for (int v = 1; v < (1 << CHK_W); v++) begin
          if ($countones(CHK_W'(v)) == w) begin
            if (idx == target) r = CHK_W'(v);
            idx++;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/clkupd_syndrome.sv
module clkupd_syndrome
  import clkupd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [CHK_W-1:0]  syn
);
  logic [CHK_W-1:0] term [WORD_W];

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_term
      assign term[b] = word[b] ? hcol(b) : '0;
    end
  endgenerate

  always_comb begin
    syn = '0;
    for (int b = 0; b < WORD_W; b++) syn = syn ^ term[b];
  end
endmodule

// File: rtl/clkupd_corrector.sv
module clkupd_corrector
  import clkupd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [CHK_W-1:0]  syn,
  output logic [WORD_W-1:0] fixed,
  output logic              flipped
);
  logic [WORD_W-1:0] leader;

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_leader
      assign leader[b] = (syn == hcol(b));
    end
  endgenerate

  assign fixed   = word ^ leader;
  assign flipped = |syn;
endmodule

// File: rtl/clkupd_unpack.sv
module clkupd_unpack
  import clkupd_pkg::*;
(
  input  logic [WORD_W-1:0] fixed,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  minute,
  output logic              pm,
  output logic              legal
);
  localparam int PM_LSB   = CHK_W;
  localparam int MIN_LSB  = PM_LSB + 1;
  localparam int HOUR_LSB = MIN_LSB + MIN_W;

  assign hour   = fixed[HOUR_LSB +: HOUR_W];
  assign minute = fixed[MIN_LSB +: MIN_W];
  assign pm     = fixed[PM_LSB];
  assign legal  = (hour != '0) && (hour <= HOUR_W'(12)) && (minute <= MIN_W'(59));
endmodule

// File: rtl/clkupd_clock.sv
module clkupd_clock
  import clkupd_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic              ld_pm,
  input  logic              tick,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  minute,
  output logic              pm
);
  localparam int SEC_W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(TICKS_PER_MIN - 1);

  logic [HOUR_W-1:0] hour_q, hour_d;
  logic [MIN_W-1:0]  min_q, min_d;
  logic              pm_q, pm_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic              clk_en;

  assign clk_en = load | tick;

  always_comb begin
    hour_d = hour_q;
    min_d  = min_q;
    pm_d   = pm_q;
    sec_d  = sec_q;
    if (load) begin
      hour_d = ld_hour;
      min_d  = ld_min;
      pm_d   = ld_pm;
      sec_d  = '0;
    end else if (tick) begin
      if (sec_q == SEC_LAST) begin
        sec_d = '0;
        if (min_q == MIN_W'(59)) begin
          min_d = '0;
          if (hour_q == HOUR_W'(12)) hour_d = HOUR_W'(1);
          else                       hour_d = hour_q + HOUR_W'(1);
          if (hour_q == HOUR_W'(11)) pm_d = ~pm_q;
        end else begin
          min_d = min_q + MIN_W'(1);
        end
      end else begin
        sec_d = sec_q + SEC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hour_q <= HOUR_W'(12);
      min_q  <= '0;
      pm_q   <= 1'b0;
      sec_q  <= '0;
    end else if (clk_en) begin
      hour_q <= hour_d;
      min_q  <= min_d;
      pm_q   <= pm_d;
      sec_q  <= sec_d;
    end
  end

  assign hour   = hour_q;
  assign minute = min_q;
  assign pm     = pm_q;
endmodule

// File: rtl/clkupd_top.sv
module clkupd_top
  import clkupd_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_word,
  input  logic              sec_tick,
  output logic [HOUR_W-1:0] hour_o,
  output logic [MIN_W-1:0]  minute_o,
  output logic              pm_o,
  output logic              err_fixed_o,
  output logic              bad_time_o
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CHK_W-1:0]  syn;
  logic [WORD_W-1:0] fixed;
  logic              flipped;
  logic [HOUR_W-1:0] u_hour;
  logic [MIN_W-1:0]  u_min;
  logic              u_pm;
  logic              u_legal;
  logic              do_load;

  clkupd_syndrome u_syn (.word(cw_word), .syn(syn));

  clkupd_corrector u_cor (
    .word(cw_word), .syn(syn), .fixed(fixed), .flipped(flipped)
  );

  clkupd_unpack u_unp (
    .fixed(fixed), .hour(u_hour), .minute(u_min), .pm(u_pm), .legal(u_legal)
  );

  assign do_load = cw_valid & u_legal;

  clkupd_clock #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_clk (
    .clk(clk), .rst_n(rst_sync_n), .load(do_load),
    .ld_hour(u_hour), .ld_min(u_min), .ld_pm(u_pm), .tick(sec_tick),
    .hour(hour_o), .minute(minute_o), .pm(pm_o)
  );

  logic err_q, err_d, bad_q, bad_d;

  always_comb begin
    err_d = cw_valid & flipped;
    bad_d = cw_valid & ~u_legal;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      err_q <= err_d;
      bad_q <= bad_d;
    end
  end

  assign err_fixed_o = err_q;
  assign bad_time_o  = bad_q;
endmodule

module clkupd_checker (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       cw_valid,
  input logic       sec_tick,
  input logic [3:0] hour_o,
  input logic [5:0] minute_o,
  input logic       pm_o,
  input logic       err_fixed_o,
  input logic       bad_time_o
);
  p_err_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_fixed_o |-> $past(cw_valid));

  p_bad_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_time_o |-> $past(cw_valid));

  p_bad_keeps_time_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bad_time_o && !$past(sec_tick)) |->
      (hour_o == $past(hour_o) && minute_o == $past(minute_o) && pm_o == $past(pm_o)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cw_valid && !sec_tick) |=> ($stable(hour_o) && $stable(minute_o) && $stable(pm_o)));

  p_hour_range_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hour_o >= 4'd1 && hour_o <= 4'd12));

  p_min_range_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (minute_o <= 6'd59));

  p_pm_toggle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pm_o != $past(pm_o) && !$past(cw_valid)) |-> (hour_o == 4'd12 && $past(hour_o) == 4'd11));
endmodule

bind clkupd_top clkupd_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cw_valid(cw_valid), .sec_tick(sec_tick),
  .hour_o(hour_o), .minute_o(minute_o), .pm_o(pm_o),
  .err_fixed_o(err_fixed_o), .bad_time_o(bad_time_o)
);

// File: tb/tb_clkupd_top.sv
module tb_clkupd_top;
  localparam int TPM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_valid = 1'b0;
  logic [14:0] cw_word = '0;
  logic        sec_tick = 1'b0;
  logic [3:0]  hour_o;
  logic [5:0]  minute_o;
  logic        pm_o, err_fixed_o, bad_time_o;

  clkupd_top #(.TICKS_PER_MIN(TPM)) dut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_word(cw_word),
    .sec_tick(sec_tick), .hour_o(hour_o), .minute_o(minute_o), .pm_o(pm_o),
    .err_fixed_o(err_fixed_o), .bad_time_o(bad_time_o)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R9";

  // R1: column list, built by enumeration of weights
  int col [15];
  initial begin
    int k;
    k = 14;
    for (int w = 2; w <= 4; w++)
      for (int v = 1; v < 16; v++)
        if ($countones(v) == w) begin col[k] = v; k--; end
    for (int c = 0; c < 4; c++) col[c] = 1 << c;
  end

  function automatic int syndrome_of(input logic [14:0] w);
    int s = 0;
    for (int b = 0; b < 15; b++) if (w[b]) s = s ^ col[b];
    return s;
  endfunction

  function automatic logic [14:0] encode(input int h, input int m, input int p);
    logic [14:0] w;
    w = '0;
    w[14:11] = 4'(h);
    w[10:5]  = 6'(m);
    w[4]     = p[0];
    w[3:0]   = 4'(syndrome_of(w));
    return w;
  endfunction

  // Behavioural reference model
  int m_h = 12, m_m = 0, m_p = 0, m_s = 0;
  bit m_err = 0, m_bad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 12; m_m = 0; m_p = 0; m_s = 0; m_err = 0; m_bad = 0;
    end else begin
      int s, h, mi, p;
      logic [14:0] fw;
      bit ok;
      m_err = 0; m_bad = 0;
      ok = 0; h = 0; mi = 0; p = 0;
      if (cw_valid) begin
        fw = cw_word;
        s = syndrome_of(fw);
        if (s != 0) begin
          m_err = 1;
          for (int b = 0; b < 15; b++) if (col[b] == s) fw[b] = ~fw[b];
        end
        h = int'(fw[14:11]); mi = int'(fw[10:5]); p = int'(fw[4]);
        ok = (h >= 1 && h <= 12 && mi <= 59);
        m_bad = !ok;
      end
      if (ok) begin
        m_h = h; m_m = mi; m_p = p; m_s = 0;
      end else if (sec_tick) begin
        m_s++;
        if (m_s == TPM) begin
          m_s = 0;
          m_m++;
          if (m_m == 60) begin
            m_m = 0;
            if (m_h == 11) m_p = 1 - m_p;
            m_h = (m_h == 12) ? 1 : m_h + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (hour_o != 4'(m_h) || minute_o != 6'(m_m) || pm_o != m_p[0] ||
          err_fixed_o != m_err || bad_time_o != m_bad) begin
        fails++;
        $display("FAIL %s: got %0d:%0d pm=%0b err=%0b bad=%0b expected %0d:%0d pm=%0d err=%0b bad=%0b",
                 cur_req, hour_o, minute_o, pm_o, err_fixed_o, bad_time_o,
                 m_h, m_m, m_p, m_err, m_bad);
      end
    end
  end

  task automatic drive(input bit v, input logic [14:0] w, input bit t);
    @(negedge clk);
    cw_valid = v; cw_word = w; sec_tick = t;
    @(negedge clk);
    cw_valid = 0; sec_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 1);
  endtask

  task automatic finish_up;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_up();
    end
  end

  initial begin
    logic [14:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);     // R9: reset state compared here

    cur_req = "R2";                // R1 encoding, R2 clean words, R4 fields
    drive(1, encode(3, 45, 1), 0);
    cur_req = "R4";
    drive(1, encode(10, 37, 0), 0);
    drive(1, encode(12, 0, 1), 0);
    drive(1, encode(1, 59, 0), 0);

    cur_req = "R3";                // every single flip
    for (int b = 0; b < 15; b++) begin
      w = encode(1 + (b % 12), (b * 7) % 60, b % 2);
      w[b] = ~w[b];
      drive(1, w, 0);
    end

    cur_req = "R5";                // illegal payloads, also with a flip
    drive(1, encode(0, 10, 0), 0);
    drive(1, encode(13, 10, 0), 0);
    drive(1, encode(5, 60, 1), 0);
    w = encode(15, 63, 1); w[2] = ~w[2];
    drive(1, w, 0);
    w = encode(0, 0, 0); w[9] = ~w[9];
    drive(1, w, 1);

    cur_req = "R6";                // update clears seconds
    drive(1, encode(4, 20, 0), 0);
    ticks(2);
    drive(1, encode(4, 30, 0), 0);
    ticks(3);
    repeat (3) @(negedge clk);
    ticks(1);

    cur_req = "R8";                // 11:59 AM -> 12:00 PM and PM -> AM
    drive(1, encode(11, 59, 0), 0);
    ticks(TPM);
    drive(1, encode(11, 59, 1), 0);
    ticks(TPM);

    cur_req = "R7";                // 12:59 -> 1:00, and a run of minutes
    drive(1, encode(12, 59, 1), 0);
    ticks(TPM);
    drive(1, encode(9, 58, 0), 0);
    ticks(TPM * 3 + 1);

    cur_req = "R10";               // update and tick together
    drive(1, encode(6, 15, 1), 0);
    ticks(TPM - 1);
    drive(1, encode(7, 5, 0), 1);
    ticks(TPM);

    cur_req = "R11";               // two flips miscorrect
    for (int b = 0; b < 14; b++) begin
      w = encode(2 + (b % 10), (b * 11) % 60, b % 2);
      w[b] = ~w[b]; w[b + 1] = ~w[b + 1];
      drive(1, w, 0);
    end

    cur_req = "R7";                // long free run with sparse ticks
    drive(1, encode(11, 50, 1), 0);
    for (int i = 0; i < 200; i++) drive(0, '0, (i % 3) != 1);

    finish_up();
  end
endmodule